// File: doc/BRIEF.md
# SPI Register Access Target

This block sits on the target side of a four-wire SPI link and turns fixed-length register-access frames into single-cycle reads and writes on a local register port. It runs entirely in a fast system clock. Select, serial clock and serial data are brought in through flop synchronizers and oversampled, so the serial clock never clocks any logic directly.

Every frame is 64 serial clock bits long and is sent most significant bit first. The first bit chooses read or write, and the next fifteen bits are the register address. A write carries 32 data bits on MOSI. A read leaves an eight-bit idle stretch after the address, and the target uses that time to fetch the register before it shifts the value back on MISO. Both kinds of frame finish with padding, an acknowledge bit and a two-bit result code, all driven by the target. Addresses at or above a parameterised limit are refused with an error code, and no local access is made for them. A read value that arrives too late to be shifted out is reported with its own error code.

Top module: `spi_regbus_target`

## Requirements
- R1: The serial clock idles low. MOSI is sampled on rising serial clock edges. MISO changes only on falling edges or when select is high, and each frame is 64 bits, most significant bit first.
- R2: Frame bit 63 is the operation, with 1 for write and 0 for read. Bits 62..48 are the 15-bit register address, and it is presented on `reg_addr` with the local strobe.
- R3: For a write frame, bits 47..16 are the write data. Once the 48th bit is captured, a single one-cycle `reg_wr` pulse is issued with that address and data.
- R4: For a read frame to a permitted address, a single one-cycle `reg_rd` pulse is issued once bit 48 (the last address bit) is captured. The value that comes back with `reg_rvalid` is returned on MISO in frame bits 39..8, most significant bit first.
- R5: Every completed frame drives frame bit 2 (acknowledge) to 1. Bits 1..0 (status) are 00 on success, and bits 7..3 are 0.
- R6: An address at or above `ADDR_LIMIT` (default 256) causes no `reg_wr` or `reg_rd`. The frame returns status 01, and a read returns all-zero data.
- R7: If `reg_rvalid` has not arrived by the time the first read-data bit (frame bit 39) must be driven, the read returns all-zero data and status 10. A later `reg_rvalid` is ignored.
- R8: If select rises before the 48th bit of a write frame, no write is made. The bit counter restarts, so the next frame decodes normally.
- R9: MISO is 0 whenever select is high. During a frame it is also 0 at every position other than read data (bits 39..8 of a read), acknowledge and status. This includes the whole write-data field.
- R10: After reset, `spi_miso`, `reg_wr` and `reg_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling and all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_csn | input | 1 | Active-low select, idles high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_wr | output | 1 | One-cycle local write strobe |
| reg_rd | output | 1 | One-cycle local read strobe |
| reg_addr | output | 15 | Local register address |
| reg_wdata | output | 32 | Local write data |
| reg_rdata | input | 32 | Local read data, valid with reg_rvalid |
| reg_rvalid | input | 1 | Local read data valid |

## Verification
The bench sweeps writes and read-backs across the permitted address space with read latencies that grow up to close to the gap deadline. A design that latched read data one bit late, or shifted it from the wrong position, would return rotated or stale words. Addresses at and just past the limit are aimed at an off-by-one range check, which would either corrupt a register or refuse a valid one. A read whose data arrives after the deadline must report status 10 rather than shift out a half-updated word. A write frame cut short after 40 bits must leave the register unchanged and must not poison the next frame, which a counter that survives select going high would do.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 32;
  localparam int GAP_BITS   = 8;
  localparam int PAD_BITS   = 5;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // Bit counts (number of rising edges seen) at which frame events fall due
  localparam int POS_ADDR_DONE  = 1 + ADDR_W;                 // 16
  localparam int POS_WDATA_DONE = POS_ADDR_DONE + DATA_W;     // 48
  localparam int POS_RD_FIRST   = POS_ADDR_DONE + GAP_BITS;   // 24
  localparam int POS_RD_LAST    = POS_RD_FIRST + DATA_W - 1;  // 55
  localparam int POS_ACK        = POS_RD_LAST + 1 + PAD_BITS; // 61

  typedef enum logic [1:0] {
    STS_OK    = 2'b00,
    STS_RANGE = 2'b01,
    STS_LATE  = 2'b10
  } sts_e;

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W:0]   limit);
    return {1'b0, a} < limit;
  endfunction

  // Bit driven on MISO for the frame position whose index equals the
  // number of rising edges already seen.
  function automatic logic tx_bit(input logic [CNT_W-1:0]  pos,
                                  input logic [DATA_W-1:0] rd,
                                  input sts_e              s);
    logic [$clog2(DATA_W)-1:0] idx;
    int p;
    p   = int'(pos);
    idx = '0;
    if (p >= POS_RD_FIRST && p <= POS_RD_LAST) begin
      idx = ($clog2(DATA_W))'(POS_RD_LAST - p);
      return rd[idx];
    end
    if (p == POS_ACK)     return 1'b1;
    if (p == POS_ACK + 1) return s[1];
    if (p == POS_ACK + 2) return s[0];
    return 1'b0;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= {STAGES{RST_VAL}};
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];

endmodule

// File: rtl/spi_tgt_frame.sv
module spi_tgt_frame
  import spi_tgt_pkg::*;
#(
  parameter int ADDR_LIMIT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_rvalid,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] rd_word,
  output sts_e              status
);

  localparam int              SH_W  = POS_WDATA_DONE;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(ADDR_LIMIT);

  logic [SH_W-1:0]   sh;
  logic              cap_q;
  logic              is_wr, in_rng, rd_wait, rd_got;
  logic [DATA_W-1:0] rd_q;

  // Named frame events
  logic addr_evt, wdata_evt, deadline, frame_full, op_rd_ok;
  assign addr_evt   = cap_q && (bit_cnt == CNT_W'(POS_ADDR_DONE));
  assign wdata_evt  = cap_q && (bit_cnt == CNT_W'(POS_WDATA_DONE));
  assign deadline   = sclk_fall && (bit_cnt == CNT_W'(POS_RD_FIRST));
  assign frame_full = (bit_cnt == CNT_W'(FRAME_BITS));
  assign op_rd_ok   = !sh[ADDR_W] && addr_ok(sh[ADDR_W-1:0], LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr <= 1'b0; reg_rd <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      bit_cnt <= '0; sh <= '0; cap_q <= 1'b0; is_wr <= 1'b0; in_rng <= 1'b0;
      rd_wait <= 1'b0; rd_got <= 1'b0; rd_q <= '0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      cap_q  <= 1'b0;
      if (!cs_act) begin
        bit_cnt <= '0; sh <= '0; is_wr <= 1'b0; in_rng <= 1'b0;
        rd_wait <= 1'b0; rd_got <= 1'b0; rd_q <= '0;
      end else begin
        if (sclk_rise && !frame_full) begin
          sh      <= {sh[SH_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          cap_q   <= 1'b1;
        end
        if (addr_evt) begin
          is_wr    <= sh[ADDR_W];
          reg_addr <= sh[ADDR_W-1:0];
          in_rng   <= addr_ok(sh[ADDR_W-1:0], LIMIT);
          reg_rd   <= op_rd_ok;
        end
        if (wdata_evt) begin
          reg_wdata <= sh[DATA_W-1:0];
          reg_wr    <= is_wr && in_rng;
        end
        if (addr_evt) begin
          rd_wait <= op_rd_ok;
        end else if (deadline) begin
          rd_wait <= 1'b0;
        end else if (rd_wait && reg_rvalid) begin
          rd_q    <= reg_rdata;
          rd_got  <= 1'b1;
          rd_wait <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (!in_rng)                status = STS_RANGE;
    else if (!is_wr && !rd_got) status = STS_LATE;
    else                        status = STS_OK;
  end

  assign rd_word = rd_q;

  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r6_access_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> ({1'b0, reg_addr} < LIMIT));
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));
  a_r7_no_late_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_got) |-> (bit_cnt <= CNT_W'(POS_RD_FIRST)));

endmodule

// File: rtl/spi_tgt_txpath.sv
module spi_tgt_txpath
  import spi_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] rd_word,
  input  sts_e              status,
  output logic              miso
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         miso <= 1'b0;
    else if (!cs_act)   miso <= 1'b0;
    else if (sclk_fall) miso <= tx_bit(bit_cnt, rd_word, status);
  end

  a_r9_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);
  a_r1_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall) |=> $stable(miso));

endmodule

// File: rtl/spi_regbus_target.sv
module spi_regbus_target
  import spi_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_LIMIT  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_csn,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        reg_wr,
  output logic        reg_rd,
  output logic [14:0] reg_addr,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata,
  input  logic        reg_rvalid
);

  localparam int NSIG = 3; // 0: select, 1: serial clock, 2: serial data

  logic [NSIG-1:0] raw, synced;
  assign raw = {spi_mosi, spi_sclk, spi_csn};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    spi_tgt_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (g == 0)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw[g]),
      .q     (synced[g])
    );
  end

  logic cs_act, sclk_s, mosi_s, sclk_d, sclk_rise, sclk_fall;
  assign cs_act = !synced[0];
  assign sclk_s = synced[1];
  assign mosi_s = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = cs_act && sclk_s && !sclk_d;
  assign sclk_fall = cs_act && !sclk_s && sclk_d;

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rd_word;
  sts_e              status;

  spi_tgt_frame #(
    .ADDR_LIMIT (ADDR_LIMIT)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .mosi_s     (mosi_s),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .bit_cnt    (bit_cnt),
    .rd_word    (rd_word),
    .status     (status)
  );

  spi_tgt_txpath u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .bit_cnt   (bit_cnt),
    .rd_word   (rd_word),
    .status    (status),
    .miso      (spi_miso)
  );

  a_r1_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sclk_rise, sclk_fall}));
  a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));

endmodule

// File: tb/sim_spi_regbus_target.sv
module sim_spi_regbus_target;

  localparam int H = 8; // system clocks per serial half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, reg_wr, reg_rd, reg_rvalid;
  logic [14:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  spi_regbus_target u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  // Register file model with programmable read latency
  logic [31:0] mem [0:255];
  int          rd_lat = 3;
  int          lat_cnt = 0;
  logic        pend = 1'b0;
  logic [7:0]  raddr = '0;
  int          n_wr = 0, n_rd = 0;
  logic [14:0] last_wa = '0;
  logic [31:0] last_wd = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;

  always @(posedge clk) begin
    reg_rvalid <= 1'b0;
    if (reg_wr) begin
      mem[reg_addr[7:0]] <= reg_wdata;
      n_wr <= n_wr + 1; last_wa <= reg_addr; last_wd <= reg_wdata;
    end
    if (reg_rd) begin
      pend <= 1'b1; lat_cnt <= rd_lat; raddr <= reg_addr[7:0]; n_rd <= n_rd + 1;
    end else if (pend) begin
      if (lat_cnt <= 1) begin
        reg_rvalid <= 1'b1; reg_rdata <= mem[raddr]; pend <= 1'b0;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [63:0] tx, input int nbits, output logic [63:0] rx);
    rx = '0;
    @(negedge clk);
    spi_csn = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[63-i];
      repeat (H) @(negedge clk);
      spi_sclk = 1'b1;
      rx[63-i] = spi_miso;
      repeat (H) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    spi_csn = 1'b1; spi_mosi = 1'b0;
    repeat (4*H) @(negedge clk);
  endtask

  function automatic logic [63:0] wr_frame(input logic [14:0] a, input logic [31:0] d);
    return {1'b1, a, d, 16'h0};
  endfunction
  function automatic logic [63:0] rd_frame(input logic [14:0] a);
    return {1'b0, a, 48'h0};
  endfunction
  function automatic logic [63:0] exp_rd(input logic [31:0] d, input logic [1:0] s);
    return {24'h0, d, 5'h0, 1'b1, s};
  endfunction
  function automatic logic [63:0] exp_wr(input logic [1:0] s);
    return {61'h0, 1'b1, s};
  endfunction

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] rx;
    int w0, r0;
    repeat (10) @(negedge clk);
    // R10: reset state
    check({spi_miso, reg_wr, reg_rd} == 3'b000, "R10 reset", {61'h0, spi_miso, reg_wr, reg_rd}, 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(spi_miso == 1'b0, "R9 idle miso", {63'h0, spi_miso}, 64'h0);

    // R2 R3 R5 R9: write sweep across the permitted range
    for (int k = 0; k < 16; k++) begin
      logic [14:0] a; logic [31:0] d;
      a = 15'(k * 17); d = 32'h5A0F_0000 + k * 32'h0103_0507;
      w0 = n_wr;
      xfer(wr_frame(a, d), 64, rx);
      check(rx == exp_wr(2'b00), "R5 R9 write response", rx, exp_wr(2'b00));
      check(n_wr == w0 + 1, "R3 one write strobe", 64'(n_wr - w0), 64'd1);
      check({last_wa, last_wd} == {a, d}, "R2 R3 write addr/data", {17'h0, last_wa, last_wd}, {17'h0, a, d});
    end

    // R4 R5: read back with varying latency inside the gap
    for (int k = 0; k < 16; k++) begin
      logic [14:0] a; logic [31:0] d;
      a = 15'(k * 17); d = 32'h5A0F_0000 + k * 32'h0103_0507;
      rd_lat = 2 + k * 7; r0 = n_rd;
      xfer(rd_frame(a), 64, rx);
      check(rx == exp_rd(d, 2'b00), "R4 read data", rx, exp_rd(d, 2'b00));
      check(n_rd == r0 + 1, "R4 one read strobe", 64'(n_rd - r0), 64'd1);
    end
    rd_lat = 3;

    // R6: out-of-range write, alias location untouched
    w0 = n_wr;
    xfer(wr_frame(15'h0105, 32'hDEAD_BEEF), 64, rx);
    check(rx == exp_wr(2'b01), "R6 range write status", rx, exp_wr(2'b01));
    check(n_wr == w0, "R6 no write", 64'(n_wr - w0), 64'd0);
    xfer(rd_frame(15'h0005), 64, rx);
    check(rx == exp_rd(32'hC0DE_0005, 2'b00), "R6 alias intact", rx, exp_rd(32'hC0DE_0005, 2'b00));

    // R6: out-of-range reads at the limit and at the top
    r0 = n_rd;
    xfer(rd_frame(15'h0100), 64, rx);
    check(rx == exp_rd(32'h0, 2'b01), "R6 read at limit", rx, exp_rd(32'h0, 2'b01));
    xfer(rd_frame(15'h7FFF), 64, rx);
    check(rx == exp_rd(32'h0, 2'b01), "R6 read top", rx, exp_rd(32'h0, 2'b01));
    check(n_rd == r0, "R6 no read strobe", 64'(n_rd - r0), 64'd0);

    // R7: read data late
    rd_lat = 200;
    xfer(rd_frame(15'h0011), 64, rx);
    check(rx == exp_rd(32'h0, 2'b10), "R7 late read", rx, exp_rd(32'h0, 2'b10));
    rd_lat = 3;
    repeat (300) @(negedge clk);
    xfer(rd_frame(15'h0011), 64, rx);
    check(rx == exp_rd(32'h5A0F_0000 + 32'h0103_0507, 2'b00), "R7 recovery read", rx,
          exp_rd(32'h5A0F_0000 + 32'h0103_0507, 2'b00));

    // R8: aborted write, then normal frames
    w0 = n_wr;
    xfer(wr_frame(15'h0022, 32'h1234_5678), 40, rx);
    check(n_wr == w0, "R8 abort no write", 64'(n_wr - w0), 64'd0);
    xfer(rd_frame(15'h0022), 20, rx);
    xfer(rd_frame(15'h0022), 64, rx);
    check(rx == exp_rd(32'h5A0F_0000 + 2 * 32'h0103_0507, 2'b00), "R8 after abort", rx,
          exp_rd(32'h5A0F_0000 + 2 * 32'h0103_0507, 2'b00));
    check(spi_miso == 1'b0, "R9 idle miso end", {63'h0, spi_miso}, 64'h0);

    summary();
    $finish;
  end

endmodule